// File: doc/BRIEF.md
# Multi-Format Audio Serial Port

This block moves one stereo stream between a parallel core interface and a four-wire serial audio link made of a bit clock, a word clock, a receive data line and a transmit data line. Both clocks come in from outside. They are oversampled by the block's system clock, so the block has a single clock domain. The framing can be left-justified, right-justified, I2S, DSP or TDM. Every format is MSB first, and the word length can be 16, 20, 24 or 32 bits.

The frame length is learned: at each frame start the block records how many bit clocks the previous frame held, and takes half of that as the half-frame. The transmitter uses this length to predict the next bit, so it can drive the first data bit on the falling edge that comes before the frame-start rising edge. In left-justified, DSP and TDM framing a start offset of 0 to 255 bit clocks moves the data within the frame. The transmit line has an enable output that drops outside the active slots, so several devices can share one data wire. Received words go to the core with a one-cycle strobe. Transmit words are taken from the core once per frame.

Top module: `aud_serial_port`

## Requirements
- R1: A frame starts at the bit-clock rising edge where the sampled word clock is first seen high after being low. The exception is I2S with `wclk_pulse`=0, where a frame starts where the word clock is first seen low after being high. The start bit has frame index 0.
- R2: `wlen` selects the word length: 0=16, 1=20, 2=24, 3=32 bits. Serial words are sent MSB first. Parallel words use bits W-1..0 and receive words have zero upper bits.
- R3: `mode`=0 (left-justified): the left MSB is at index `offset` and the right MSB is at index H+`offset`, where H is half the frame length.
- R4: `mode`=1 (right-justified): the left LSB is at index H-1 and the right LSB at index 2H-1. `offset` has no effect.
- R5: `mode`=2 (I2S): the left MSB is at index 1 and the right MSB at H+1. `offset` has no effect.
- R6: `mode`=3 (DSP) and `mode`=4 (TDM): the left MSB is at index `offset` and the right word follows the left LSB immediately. Codes 5 to 7 behave as DSP.
- R7: DIN is sampled at bit-clock rising edges. `dout` and `dout_oe` change only in the system cycle after a detected bit-clock falling edge.
- R8: `frame_stb` pulses for exactly one cycle at each frame start from the third start after reset. `rx_left`/`rx_right` then hold the words of the frame that just ended, and they change at no other time.
- R9: Outside the active slots `dout` is 0. `dout_oe` is low there when `hiz_en`=1 or `mode`=4, and high otherwise. Inside a slot `dout_oe` is 1.
- R10: The transmit words are taken at the falling edge that precedes index 0 and are sent during that frame.
- R11: After reset, `dout`, `dout_oe`, `frame_stb`, `rx_left` and `rx_right` are all 0.
- R12: Transmission of slot data starts only after the second frame start following reset. The frame length comes from the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial clocks |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Serial bit clock |
| wclk | input | 1 | Serial word clock (pulse or square wave) |
| din | input | 1 | Serial receive data |
| dout | output | 1 | Serial transmit data |
| dout_oe | output | 1 | Output enable for `dout`; low means high impedance |
| mode | input | 3 | Framing: 0 LJ, 1 RJ, 2 I2S, 3 DSP, 4 TDM |
| wlen | input | 2 | Word length code |
| offset | input | 8 | Start offset in bit clocks (LJ, DSP, TDM) |
| wclk_pulse | input | 1 | 1: word clock is a pulse, frame starts on its rise in every mode |
| hiz_en | input | 1 | Release `dout` outside the active slots |
| tx_left | input | 32 | Left transmit word |
| tx_right | input | 32 | Right transmit word |
| rx_left | output | 32 | Last received left word |
| rx_right | output | 32 | Last received right word |
| frame_stb | output | 1 | One-cycle pulse when new receive words are presented |

## Verification
Some properties are checked on every cycle. `dout` and its enable move only right after a detected bit-clock fall. A released line carries 0. The strobe lasts one cycle. The receive words stay still between strobes. Each bit-clock edge produces one event. Slot placement for each format, word length and offset can only be shown by the bench's scenarios, which loop serial data back against arithmetically computed positions, as can the rule that an offset is ignored in right-justified and I2S framing. The same holds for the start-up latency of two or three frames and the frame-boundary capture of the transmit words.

// File: rtl/asp_pkg.sv
package asp_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    FMT_LJ  = 3'd0,
    FMT_RJ  = 3'd1,
    FMT_I2S = 3'd2,
    FMT_DSP = 3'd3,
    FMT_TDM = 3'd4
  } fmt_e;

  typedef struct packed {
    logic       valid;
    logic       right;
    logic [4:0] bitn;
  } slot_t;

  function automatic int word_bits(logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 20;
      2'd2:    return 24;
      default: return 32;
    endcase
  endfunction

  // Map a frame index to the channel and bit it carries.
  function automatic slot_t slot_of(fmt_e f, logic [1:0] wl, logic [7:0] off,
                                    int idx, int half);
    int w, ls, rs;
    slot_t s;
    w = word_bits(wl);
    case (f)
      FMT_LJ:  begin ls = int'(off);   rs = half + int'(off); end
      FMT_RJ:  begin ls = half - w;    rs = 2 * half - w;     end
      FMT_I2S: begin ls = 1;           rs = half + 1;         end
      default: begin ls = int'(off);   rs = int'(off) + w;    end
    endcase
    s = '0;
    if (idx >= ls && idx < ls + w) begin
      s.valid = 1'b1;
      s.right = 1'b0;
      s.bitn  = 5'(w - 1 - (idx - ls));
    end else if (idx >= rs && idx < rs + w) begin
      s.valid = 1'b1;
      s.right = 1'b1;
      s.bitn  = 5'(w - 1 - (idx - rs));
    end
    return s;
  endfunction
endpackage

// File: rtl/asp_sync_edge.sv
module asp_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk,
  input  logic wclk,
  input  logic din,
  output logic rise,
  output logic fall,
  output logic wclk_s,
  output logic din_s
);
  localparam int MSB = STAGES - 1;

  logic [STAGES-1:0] b_sr, w_sr, d_sr;
  logic              b_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      b_sr   <= '0;
      w_sr   <= '0;
      d_sr   <= '0;
      b_prev <= 1'b0;
    end else begin
      b_sr   <= {b_sr[STAGES-2:0], bclk};
      w_sr   <= {w_sr[STAGES-2:0], wclk};
      d_sr   <= {d_sr[STAGES-2:0], din};
      b_prev <= b_sr[MSB];
    end
  end

  assign rise   = b_sr[MSB] & ~b_prev;
  assign fall   = ~b_sr[MSB] & b_prev;
  assign wclk_s = w_sr[MSB];
  assign din_s  = d_sr[MSB];
endmodule

// File: rtl/asp_framer.sv
module asp_framer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic             wclk_s,
  input  logic             din_s,
  input  logic             start_on_fall,
  output logic             bit_ev,
  output logic [CNT_W-1:0] bit_idx,
  output logic             bit_start,
  output logic             bit_din,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W:0]   flen,
  output logic [1:0]       starts
);
  logic w_prev, start;

  always_comb
    start = start_on_fall ? (w_prev & ~wclk_s) : (~w_prev & wclk_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      w_prev    <= 1'b0;
      cnt       <= '0;
      flen      <= '0;
      starts    <= '0;
      bit_ev    <= 1'b0;
      bit_idx   <= '0;
      bit_start <= 1'b0;
      bit_din   <= 1'b0;
    end else begin
      bit_ev <= 1'b0;
      if (rise) begin
        w_prev <= wclk_s;
        if (start) begin
          cnt     <= '0;
          bit_idx <= '0;
          flen    <= {1'b0, cnt} + 1'b1;
          if (starts != 2'd3) starts <= starts + 2'd1;
        end else if (!(&cnt)) begin
          cnt     <= cnt + 1'b1;
          bit_idx <= cnt + 1'b1;
        end
        bit_ev    <= 1'b1;
        bit_start <= start;
        bit_din   <= din_s;
      end
    end
  end

  // R7: each bit-clock rising edge yields a single one-cycle event
  p_one_event_r7: assert property (@(posedge clk) disable iff (rst)
    bit_ev |=> !bit_ev);
endmodule

// File: rtl/asp_rx.sv
module asp_rx
  import asp_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_ev,
  input  logic [CNT_W-1:0]  bit_idx,
  input  logic              bit_start,
  input  logic              bit_din,
  input  logic [CNT_W:0]    flen,
  input  logic [1:0]        starts,
  input  fmt_e              fmt,
  input  logic [1:0]        wl,
  input  logic [7:0]        off,
  output logic [WORD_W-1:0] rx_l,
  output logic [WORD_W-1:0] rx_r,
  output logic              frame_stb
);
  slot_t             sl;
  logic [WORD_W-1:0] acc_l, acc_r, nxt_l, nxt_r;

  always_comb begin
    sl    = slot_of(fmt, wl, off, int'(bit_idx), int'(flen >> 1));
    nxt_l = bit_start ? '0 : acc_l;
    nxt_r = bit_start ? '0 : acc_r;
    if (sl.valid && !sl.right) nxt_l[sl.bitn] = bit_din;
    if (sl.valid &&  sl.right) nxt_r[sl.bitn] = bit_din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_l     <= '0;
      acc_r     <= '0;
      rx_l      <= '0;
      rx_r      <= '0;
      frame_stb <= 1'b0;
    end else begin
      frame_stb <= 1'b0;
      if (bit_ev) begin
        acc_l <= nxt_l;
        acc_r <= nxt_r;
        if (bit_start && starts == 2'd3) begin
          rx_l      <= acc_l;
          rx_r      <= acc_r;
          frame_stb <= 1'b1;
        end
      end
    end
  end

  // R8: strobe is a single-cycle pulse
  p_stb_single_r8: assert property (@(posedge clk) disable iff (rst)
    frame_stb |=> !frame_stb);
  // R8: receive words move only together with the strobe
  p_words_steady_r8: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |-> ($stable(rx_l) && $stable(rx_r)));
endmodule

// File: rtl/asp_tx.sv
module asp_tx
  import asp_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W:0]    flen,
  input  logic [1:0]        starts,
  input  fmt_e              fmt,
  input  logic [1:0]        wl,
  input  logic [7:0]        off,
  input  logic              hiz_en,
  input  logic [WORD_W-1:0] tx_l,
  input  logic [WORD_W-1:0] tx_r,
  output logic              dout,
  output logic              dout_oe
);
  logic [CNT_W:0]    inc, nxt;
  logic [WORD_W-1:0] hold_l, hold_r, word;
  slot_t             sl;
  logic              release_idle, armed;

  always_comb begin
    inc          = {1'b0, cnt} + 1'b1;
    nxt          = (inc == flen) ? '0 : inc;
    sl           = slot_of(fmt, wl, off, int'(nxt), int'(flen >> 1));
    if (nxt == '0) word = sl.right ? tx_r : tx_l;
    else           word = sl.right ? hold_r : hold_l;
    release_idle = hiz_en || (fmt == FMT_TDM);
    armed        = starts[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_l  <= '0;
      hold_r  <= '0;
      dout    <= 1'b0;
      dout_oe <= 1'b0;
    end else if (fall) begin
      if (nxt == '0) begin
        hold_l <= tx_l;
        hold_r <= tx_r;
      end
      if (armed && sl.valid) begin
        dout    <= word[sl.bitn];
        dout_oe <= 1'b1;
      end else begin
        dout    <= 1'b0;
        dout_oe <= !release_idle;
      end
    end
  end

  // R7: the line only moves right after a detected bit-clock fall
  p_dout_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
    ($changed(dout) || $changed(dout_oe)) |-> $past(fall));
  // R9: a released line carries 0
  p_idle_low_r9: assert property (@(posedge clk) disable iff (rst)
    !dout_oe |-> !dout);
endmodule

// File: rtl/aud_serial_port.sv
module aud_serial_port
  import asp_pkg::*;
#(
  parameter int CNT_W  = 9,
  parameter int STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bclk,
  input  logic        wclk,
  input  logic        din,
  output logic        dout,
  output logic        dout_oe,
  input  logic [2:0]  mode,
  input  logic [1:0]  wlen,
  input  logic [7:0]  offset,
  input  logic        wclk_pulse,
  input  logic        hiz_en,
  input  logic [31:0] tx_left,
  input  logic [31:0] tx_right,
  output logic [31:0] rx_left,
  output logic [31:0] rx_right,
  output logic        frame_stb
);
  fmt_e             fmt;
  logic             rise, fall, wclk_s, din_s, on_fall;
  logic             bit_ev, bit_start, bit_din;
  logic [CNT_W-1:0] bit_idx, cnt;
  logic [CNT_W:0]   flen;
  logic [1:0]       starts;

  assign fmt     = fmt_e'(mode);
  assign on_fall = (fmt == FMT_I2S) && !wclk_pulse;

  asp_sync_edge #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .bclk(bclk), .wclk(wclk), .din(din),
    .rise(rise), .fall(fall), .wclk_s(wclk_s), .din_s(din_s));

  asp_framer #(.CNT_W(CNT_W)) u_framer (
    .clk(clk), .rst(rst), .rise(rise), .wclk_s(wclk_s), .din_s(din_s),
    .start_on_fall(on_fall), .bit_ev(bit_ev), .bit_idx(bit_idx),
    .bit_start(bit_start), .bit_din(bit_din), .cnt(cnt), .flen(flen),
    .starts(starts));

  asp_rx #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .bit_ev(bit_ev), .bit_idx(bit_idx),
    .bit_start(bit_start), .bit_din(bit_din), .flen(flen), .starts(starts),
    .fmt(fmt), .wl(wlen), .off(offset), .rx_l(rx_left), .rx_r(rx_right),
    .frame_stb(frame_stb));

  asp_tx #(.CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst(rst), .fall(fall), .cnt(cnt), .flen(flen),
    .starts(starts), .fmt(fmt), .wl(wlen), .off(offset), .hiz_en(hiz_en),
    .tx_l(tx_left), .tx_r(tx_right), .dout(dout), .dout_oe(dout_oe));
endmodule

// File: tb/aud_serial_port_tb.sv
module aud_serial_port_tb;
  logic        clk = 1'b0, rst = 1'b1;
  logic        bclk = 1'b0, wclk = 1'b0, din = 1'b0;
  logic        dout, dout_oe, frame_stb;
  logic [2:0]  mode = '0;
  logic [1:0]  wlen = '0;
  logic [7:0]  offset = '0;
  logic        wclk_pulse = 1'b0, hiz_en = 1'b0;
  logic [31:0] tx_left = '0, tx_right = '0, rx_left, rx_right;

  int n_chk = 0, n_fail = 0, stb_cnt = 0;
  logic [31:0] cap_l = '0, cap_r = '0, lcg = 32'h1234_5678;
  logic [31:0] txl[0:5], txr[0:5], rxl[0:5], rxr[0:5];

  always #4 clk = ~clk; // 125 MHz

  aud_serial_port u_dut (
    .clk(clk), .rst(rst), .bclk(bclk), .wclk(wclk), .din(din),
    .dout(dout), .dout_oe(dout_oe), .mode(mode), .wlen(wlen),
    .offset(offset), .wclk_pulse(wclk_pulse), .hiz_en(hiz_en),
    .tx_left(tx_left), .tx_right(tx_right), .rx_left(rx_left),
    .rx_right(rx_right), .frame_stb(frame_stb));

  always @(negedge clk)
    if (frame_stb) begin
      cap_l = rx_left;
      cap_r = rx_right;
      stb_cnt++;
    end

  function automatic logic [31:0] rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg ^ (lcg >> 13);
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected slot per the requirements: start positions of each word.
  task automatic want_slot(input int m, input int w, input int off, input int t,
                           input int h, output bit v, output bit r, output int b);
    int a0, a1;
    if (m == 0)      begin a0 = off;   a1 = h + off;  end // R3
    else if (m == 1) begin a0 = h - w; a1 = 2*h - w;  end // R4
    else if (m == 2) begin a0 = 1;     a1 = h + 1;    end // R5
    else             begin a0 = off;   a1 = off + w;  end // R6
    v = 0; r = 0; b = 0;
    if (t - a0 >= 0 && t - a0 < w)      begin v = 1; b = w - 1 - (t - a0); end
    else if (t - a1 >= 0 && t - a1 < w) begin v = 1; r = 1; b = w - 1 - (t - a1); end
  endtask

  task automatic one_bit(input logic wl, input logic d,
                         output logic so, output logic soe);
    @(negedge clk); bclk = 1'b0; wclk = wl; din = d;
    repeat (3) @(negedge clk);
    @(negedge clk); so = dout; soe = dout_oe; bclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic wlevel(input int m, input bit pulse, input int t, input int f);
    if (pulse || m >= 3) return (t == 0);       // R1 pulse framing
    if (m == 2)          return (t >= f / 2);    // R1 I2S: left while low
    return (t < f / 2);
  endfunction

  task automatic run_cfg(input int m, input int wl, input int off,
                         input bit pulse, input bit hz, input int f);
    int w, h; logic [31:0] mask; logic so, soe;
    string tg;
    w = (wl == 0) ? 16 : (wl == 1) ? 20 : (wl == 2) ? 24 : 32;
    h = f / 2;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    tg = (m == 0) ? "R3" : (m == 1) ? "R4" : (m == 2) ? "R5" : "R6";
    @(negedge clk);
    rst = 1'b1; bclk = 1'b0; wclk = 1'b0; din = 1'b0;
    mode = 3'(m); wlen = 2'(wl); offset = 8'(off);
    wclk_pulse = pulse; hiz_en = hz;
    for (int i = 0; i < 6; i++) begin
      txl[i] = rnd(); txr[i] = rnd(); rxl[i] = rnd(); rxr[i] = rnd();
    end
    tx_left = txl[0]; tx_right = txr[0];
    repeat (4) @(negedge clk);
    stb_cnt = 0;
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R11 reset state
    chk(dout === 1'b0 && dout_oe === 1'b0 && frame_stb === 1'b0 &&
        rx_left === '0 && rx_right === '0, "R11 reset outputs",
        {28'd0, dout, dout_oe, frame_stb, |{rx_left, rx_right}}, 32'd0);
    one_bit(wlevel(m, pulse, f - 1, f), 1'b0, so, soe); // preamble
    for (int j = 0; j < 4; j++) begin
      for (int t = 0; t < f; t++) begin
        bit v, r; int b; logic d;
        want_slot(m, w, off, t, h, v, r, b);
        d = v ? (r ? rxr[j][b] : rxl[j][b]) : t[0];
        one_bit(wlevel(m, pulse, t, f), d, so, soe);
        if (t == 0) begin tx_left = txl[j+1]; tx_right = txr[j+1]; end
        if (j >= 2) begin
          if (v) begin
            logic e;
            e = r ? txr[j][b] : txl[j][b];
            // R2 R7 R10 R12 slot data
            chk(soe === 1'b1 && so === e, {tg, " R2 R10 R12 dout bit"},
                {30'd0, soe, so}, {30'd0, 1'b1, e});
          end else begin
            logic eoe;
            eoe = !(hz || m == 4);
            chk(soe === eoe && so === 1'b0, "R9 idle slot",
                {30'd0, soe, so}, {30'd0, eoe, 1'b0});
          end
        end
        if (t == 2 && j == 1)
          chk(stb_cnt == 0, "R8 no early strobe", 32'(stb_cnt), 32'd0);
        if (t == 2 && j >= 2) begin
          chk(stb_cnt == j - 1, "R8 strobe count", 32'(stb_cnt), 32'(j - 1));
          chk(cap_l === (rxl[j-1] & mask), {tg, " R1 R2 R7 rx left"},
              cap_l, rxl[j-1] & mask);
          chk(cap_r === (rxr[j-1] & mask), {tg, " R1 R2 R7 rx right"},
              cap_r, rxr[j-1] & mask);
        end
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int wl = 0; wl < 4; wl++) begin
      run_cfg(0, wl, 0, 1'b0, 1'b0, 80);   // R3 LJ at frame edge
      run_cfg(0, wl, 8, 1'b0, 1'b0, 80);   // R3 LJ with offset
      run_cfg(1, wl, 9, 1'b0, 1'b0, 80);   // R4 offset ignored
      run_cfg(2, wl, 9, 1'b0, 1'b0, 80);   // R5 offset ignored
      run_cfg(3, wl, 0, 1'b1, 1'b0, 80);   // R6 DSP
      run_cfg(3, wl, 13, 1'b1, 1'b0, 80);  // R6 DSP with offset
      run_cfg(4, wl, 5, 1'b1, 1'b0, 80);   // R6 R9 TDM releases line
    end
    run_cfg(2, 2, 0, 1'b1, 1'b0, 80);      // R1 I2S with pulse word clock
    run_cfg(0, 1, 3, 1'b0, 1'b1, 80);      // R9 release in LJ via hiz_en
    run_cfg(4, 0, 200, 1'b1, 1'b0, 256);   // R6 large offset
    summary();
  end
endmodule